// File: doc/BRIEF.md
# PFC Startup Sequencing Controller

This block takes a three-phase active rectifier stage from power-up to closed-loop bus regulation. After an initialisation cycle it waits for the ADC offset check to pass. It then watches the bus-voltage sample stream until the bus stops rising, and commands the relay that shorts out the inrush-limiting resistor. After the relay closes, it waits for the bus to settle a second time. It then starts regulation with a one-cycle strobe and hands the control loop a bus-voltage reference. That reference climbs from zero in slope-limited steps until it reaches the programmed target.

The bus counts as settled once a programmable number of consecutive sample pairs each differ by less than a programmable delta. The settle count restarts on every wait phase. The reference moves only on a control tick, and it stops exactly on the target code. A nominal 700 V target is simply one value of that code. An active fault-stop input returns the sequence to initialisation: the relay command opens and the reference drops to zero. When fault-stop is released, the sequence starts again from the beginning. The policy for recovering from a fault is left to the logic that drives the fault-stop input.

Top module: `pfc_startup_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `relay_close` and `reg_start` are 0 and `vref` is 0.
- R2: While `offset_ok` is low, the sequence never leaves offset verification. `relay_close` stays 0 whatever samples arrive, and samples taken before the inrush phase do not count toward settling.
- R3: A sample pair counts toward settling when the absolute difference of the two samples is strictly below `flat_delta`. A pair whose difference is `flat_delta` or more sets the count back to zero. The bus is settled once the count reaches `flat_count` (1 or more). Cycles with `sample_vld` low neither add to nor reset the count.
- R4: `relay_close` rises one cycle after the edge that accepts the sample completing the first settled run in the inrush phase. It then stays high until fault-stop.
- R5: A sample presented in the cycle in which the relay closes is discarded. The second settle wait starts with no previous sample. `reg_start` is a single-cycle pulse, raised one cycle after the edge that accepts the sample completing the second settled run.
- R6: `vref` is 0 before regulation, including in the cycle `reg_start` is high. During regulation, each cycle with `ctrl_tick` high adds `slope_step` to `vref`, and a cycle without a tick leaves it unchanged.
- R7: `vref` never exceeds `target_code`. A tick that would pass the target loads exactly `target_code`, and later ticks hold that value.
- R8: `ctrl_tick` has no effect on `vref` outside the regulation phase.
- R9: An active `fault_stop` forces, by the next cycle, `relay_close`=0, `reg_start`=0 and `vref`=0. After release, the full sequence runs again, including offset verification and both settle waits from an empty count.
- R10: When `fault_stop` is high in the same cycle in which a settled run would close the relay, the fault wins and the relay stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_stop | input | 1 | Forces the sequence back to initialisation |
| offset_ok | input | 1 | ADC offset verification passed |
| sample_vld | input | 1 | New bus-voltage sample present |
| sample_bus | input | BUS_W | Bus-voltage sample code |
| flat_delta | input | BUS_W | Exclusive limit on the difference between successive samples |
| flat_count | input | CNT_W | Number of consecutive quiet pairs that means settled |
| target_code | input | BUS_W | Final regulation target |
| slope_step | input | BUS_W | Reference increment per control tick |
| ctrl_tick | input | 1 | Control-loop tick that advances the ramp |
| relay_close | output | 1 | Command to close the inrush-bypass relay |
| reg_start | output | 1 | One-cycle strobe when regulation begins |
| vref | output | BUS_W | Ramped bus-voltage reference |

## Verification
Two functions can land on the same clock edge. The first pair is fault-stop and the settle detector completing a run, which would close the relay. The bench lines up a run of identical samples so that the run completes in the cycle where fault-stop is raised, and it expects the relay command to stay open (R10). The second pair is a control tick and the settle detector's restart on the relay-closing cycle. Here a tick arrives in the cycle before regulation starts, and a sample is presented in the cycle the relay closes. The bench judges both by exact cycle timing: `vref` must still read zero when `reg_start` is high, and the second settle wait must take one more sample than it would if the discarded sample had counted.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_OFFSET  = 3'd1,
        ST_INRUSH  = 3'd2,
        ST_SETTLE2 = 3'd3,
        ST_REGUL   = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic relay;
        logic start;
        logic ramp_run;
        logic det_clear;
    } seq_cmd_t;

    function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [32:0] sat_sum(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] lim);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s >= {1'b0, lim}) ? {1'b0, lim} : s;
    endfunction

endpackage

// File: rtl/pfc_flat_detect.sv
module pfc_flat_detect
    import pfc_seq_pkg::*;
#(
    parameter int BUS_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample_vld,
    input  logic [BUS_W-1:0] sample_bus,
    input  logic [BUS_W-1:0] flat_delta,
    input  logic [CNT_W-1:0] flat_count,
    output logic             flat
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic [BUS_W-1:0] prev_q;
    logic             have_prev_q;
    logic [CNT_W-1:0] run_q;
    logic [31:0]      gap;
    logic             quiet;

    assign gap   = abs_gap(32'(sample_bus), 32'(prev_q));
    assign quiet = gap < 32'(flat_delta);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            run_q       <= '0;
        end else if (sample_vld) begin
            prev_q      <= sample_bus;
            have_prev_q <= 1'b1;
            if (have_prev_q) begin
                if (!quiet)
                    run_q <= '0;
                else if (run_q != RUN_MAX)
                    run_q <= run_q + 1'b1;
            end
        end
    end

    assign flat = have_prev_q && (run_q >= flat_count);
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
    import pfc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fault_stop,
    input  logic     offset_ok,
    input  logic     flat,
    output seq_cmd_t cmd
);
    seq_state_t state_q, state_d;
    logic       start_q;
    logic       adv_relay, adv_reg, tracking;

    assign adv_relay = !fault_stop && (state_q == ST_INRUSH)  && flat;
    assign adv_reg   = !fault_stop && (state_q == ST_SETTLE2) && flat;
    assign tracking  = (state_q == ST_INRUSH) || (state_q == ST_SETTLE2);

    always_comb begin
        state_d = state_q;
        if (fault_stop) begin
            state_d = ST_INIT;
        end else begin
            unique case (state_q)
                ST_INIT:    state_d = ST_OFFSET;
                ST_OFFSET:  if (offset_ok) state_d = ST_INRUSH;
                ST_INRUSH:  if (adv_relay) state_d = ST_SETTLE2;
                ST_SETTLE2: if (adv_reg)   state_d = ST_REGUL;
                ST_REGUL:   state_d = ST_REGUL;
                default:    state_d = ST_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= adv_reg;
        end
    end

    always_comb begin
        cmd.relay     = (state_q == ST_SETTLE2) || (state_q == ST_REGUL);
        cmd.start     = start_q;
        cmd.ramp_run  = (state_q == ST_REGUL) && !fault_stop;
        cmd.det_clear = fault_stop || !tracking || adv_relay || adv_reg;
    end
endmodule

// File: rtl/pfc_ref_ramp.sv
module pfc_ref_ramp
    import pfc_seq_pkg::*;
#(
    parameter int BUS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [BUS_W-1:0] target_code,
    input  logic [BUS_W-1:0] slope_step,
    output logic [BUS_W-1:0] vref
);
    logic [BUS_W-1:0] ref_q;
    logic [32:0]      nxt;

    assign nxt = sat_sum(32'(ref_q), 32'(slope_step), 32'(target_code));

    always_ff @(posedge clk) begin
        if (rst || !run)
            ref_q <= '0;
        else if (tick)
            ref_q <= nxt[BUS_W-1:0];
    end

    assign vref = ref_q;
endmodule

// File: rtl/pfc_startup_seq.sv
module pfc_startup_seq
    import pfc_seq_pkg::*;
#(
    parameter int BUS_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_stop,
    input  logic             offset_ok,
    input  logic             sample_vld,
    input  logic [BUS_W-1:0] sample_bus,
    input  logic [BUS_W-1:0] flat_delta,
    input  logic [CNT_W-1:0] flat_count,
    input  logic [BUS_W-1:0] target_code,
    input  logic [BUS_W-1:0] slope_step,
    input  logic             ctrl_tick,
    output logic             relay_close,
    output logic             reg_start,
    output logic [BUS_W-1:0] vref
);
    seq_cmd_t cmd;
    logic     flat;

    pfc_flat_detect #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_flat (
        .clk        (clk),
        .rst        (rst),
        .clear      (cmd.det_clear),
        .sample_vld (sample_vld),
        .sample_bus (sample_bus),
        .flat_delta (flat_delta),
        .flat_count (flat_count),
        .flat       (flat)
    );

    pfc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fault_stop (fault_stop),
        .offset_ok  (offset_ok),
        .flat       (flat),
        .cmd        (cmd)
    );

    pfc_ref_ramp #(.BUS_W(BUS_W)) u_ramp (
        .clk         (clk),
        .rst         (rst),
        .run         (cmd.ramp_run),
        .tick        (ctrl_tick),
        .target_code (target_code),
        .slope_step  (slope_step),
        .vref        (vref)
    );

    assign relay_close = cmd.relay;
    assign reg_start   = cmd.start;
endmodule

// File: rtl/pfc_startup_seq_chk.sv
module pfc_startup_seq_chk #(
    parameter int BUS_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             fault_stop,
    input logic             ctrl_tick,
    input logic [BUS_W-1:0] target_code,
    input logic             relay_close,
    input logic             reg_start,
    input logic [BUS_W-1:0] vref
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!relay_close && !reg_start && vref == '0)); // R1

    AST_RELAY_HELD: assert property (@(posedge clk) disable iff (rst)
        (relay_close && !fault_stop) |=> relay_close); // R4

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_start |=> !reg_start); // R5

    AST_VREF_NEEDS_RELAY: assert property (@(posedge clk) disable iff (rst)
        !relay_close |-> (vref == '0)); // R6

    AST_VREF_STILL_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_tick && !fault_stop) |=> $stable(vref)); // R6

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        (ctrl_tick && !fault_stop && vref <= target_code) |=> (vref <= $past(target_code))); // R7

    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        fault_stop |=> (!relay_close && !reg_start && vref == '0)); // R9
endmodule

bind pfc_startup_seq pfc_startup_seq_chk #(.BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fault_stop  (fault_stop),
    .ctrl_tick   (ctrl_tick),
    .target_code (target_code),
    .relay_close (relay_close),
    .reg_start   (reg_start),
    .vref        (vref)
);

// File: tb/pfc_startup_seq_bench.sv
module pfc_startup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 12;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fault_stop = 1'b0;
    logic          offset_ok = 1'b0;
    logic          sample_vld = 1'b0;
    logic [BW-1:0] sample_bus = '0;
    logic [BW-1:0] flat_delta = 12'd4;
    logic [CW-1:0] flat_count = 8'd3;
    logic [BW-1:0] target_code = 12'd700;
    logic [BW-1:0] slope_step = 12'd64;
    logic          ctrl_tick = 1'b0;
    logic          relay_close;
    logic          reg_start;
    logic [BW-1:0] vref;

    typedef struct {
        bit            chk;
        logic          relay;
        logic          start;
        logic [BW-1:0] vr;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   timed_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfc_startup_seq #(.BUS_W(BW), .CNT_W(CW)) u_pfc_startup_seq (
        .clk(clk), .rst(rst), .fault_stop(fault_stop), .offset_ok(offset_ok),
        .sample_vld(sample_vld), .sample_bus(sample_bus), .flat_delta(flat_delta),
        .flat_count(flat_count), .target_code(target_code), .slope_step(slope_step),
        .ctrl_tick(ctrl_tick), .relay_close(relay_close), .reg_start(reg_start), .vref(vref)
    );

    // driver: inputs for one cycle plus the outputs expected after its edge
    task automatic cyc(input logic r, input logic fs, input logic ok, input logic sv,
                       input logic [BW-1:0] s, input logic tk, input bit chk,
                       input logic er, input logic es, input logic [BW-1:0] ev, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; fault_stop = fs; offset_ok = ok; sample_vld = sv; sample_bus = s; ctrl_tick = tk;
        e.chk = chk; e.relay = er; e.start = es; e.vr = ev; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                if (e.chk) begin
                    n_cmp++;
                    if (relay_close !== e.relay || reg_start !== e.start || vref !== e.vr) begin
                        n_bad++;
                        $display("FAIL %s: relay=%b start=%b vref=%0d expected relay=%b start=%b vref=%0d",
                                 e.tag, relay_close, reg_start, vref, e.relay, e.start, e.vr);
                    end
                end
            end
        end
    end

    task automatic run_all();
        // R1 reset
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R1 in reset");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R1 after reset");
        // R2 / R8: no offset_ok, flat samples and ticks must do nothing
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, 12'd500, 1, 1, 0, 0, 0, "R2 R8 offset wait");
        cyc(0, 0, 1, 1, 12'd500, 0, 1, 0, 0, 0, "R2 enter inrush");
        // R3: inrush settle wait, delta boundary and gap cycles
        cyc(0, 0, 1, 1, 12'd500, 0, 1, 0, 0, 0, "R3 first sample");
        cyc(0, 0, 1, 1, 12'd502, 0, 1, 0, 0, 0, "R3 run 1");
        cyc(0, 0, 1, 1, 12'd506, 0, 1, 0, 0, 0, "R3 gap equal delta resets");
        cyc(0, 0, 1, 1, 12'd507, 0, 1, 0, 0, 0, "R3 run 1 again");
        cyc(0, 0, 1, 0, 12'd900, 0, 1, 0, 0, 0, "R3 invalid ignored");
        cyc(0, 0, 1, 1, 12'd509, 0, 1, 0, 0, 0, "R3 run 2");
        cyc(0, 0, 1, 1, 12'd510, 0, 1, 0, 0, 0, "R3 run 3 no relay yet");
        // R4 relay closes; R5 sample in this cycle is discarded
        cyc(0, 0, 1, 1, 12'd700, 0, 1, 1, 0, 0, "R4 relay closes");
        cyc(0, 0, 1, 1, 12'd701, 0, 1, 1, 0, 0, "R5 first kept sample");
        cyc(0, 0, 1, 1, 12'd702, 0, 1, 1, 0, 0, "R5 run 1");
        cyc(0, 0, 1, 1, 12'd703, 0, 1, 1, 0, 0, "R5 run 2 no start");
        cyc(0, 0, 1, 1, 12'd704, 0, 1, 1, 0, 0, "R5 run 3 no start yet");
        // tick in the transition cycle must not move vref
        cyc(0, 0, 1, 0, 12'd0, 1, 1, 1, 1, 0, "R5 R6 start strobe vref zero");
        cyc(0, 0, 1, 0, 12'd0, 0, 1, 1, 0, 0, "R5 strobe single cycle");
        // R6 / R7 ramp
        for (int k = 1; k <= 10; k++) cyc(0, 0, 1, 0, 0, 1, 1, 1, 0, 12'(64 * k), "R6 ramp step");
        cyc(0, 0, 1, 0, 0, 0, 1, 1, 0, 12'd640, "R6 no tick holds");
        cyc(0, 0, 1, 0, 0, 1, 1, 1, 0, 12'd700, "R7 saturate at target");
        cyc(0, 0, 1, 0, 0, 1, 1, 1, 0, 12'd700, "R7 hold at target");
        // R9 fault
        cyc(0, 1, 1, 0, 0, 1, 1, 0, 0, 0, "R9 fault clears");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 back to init");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 12'd300, 1, 1, 0, 0, 0, "R9 offset again");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R9 enter inrush");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 12'd300, 0, 1, 0, 0, 0, "R9 fresh run");
        // R10 fault in the closing cycle wins
        cyc(0, 1, 1, 0, 0, 0, 1, 0, 0, 0, "R10 fault beats relay");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R10 init");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R10 offset");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 12'd300, 0, 1, 0, 0, 0, "R9 run after restart");
        cyc(0, 0, 1, 0, 0, 0, 1, 1, 0, 0, "R9 relay after restart");
        @(posedge clk);
        #(CLK_PERIOD/2);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule